// File: doc/BRIEF.md
# Byte-Lane Parity Checker

This block watches a 36-bit data port and checks every transferred word as four independent 9-bit byte lanes. Each lane carries eight data bits and one parity bit. Whenever the port strobes a valid word, every lane is tested against the parity sense currently selected, and a single registered flag reports whether any lane broke parity.

The parity sense is held in a one-bit mode field, bit 0 of a small control register. A host may rewrite it at any time through a write strobe and a data bit. Reset selects odd parity. The flag keeps its value between valid words, so downstream logic can sample it at its leisure.

Top module: `byte_parity_checker`

## Requirements
- R1: Lane i occupies word bits [9i+8:9i]: the lane's data is its bits [7:0] and its parity bit is its bit [8]. So the four lanes are [8:0], [17:9], [26:18] and [35:27].
- R2: With the mode bit at 0 (odd sense), a lane passes when its nine bits hold an odd number of ones, and fails otherwise.
- R3: With the mode bit at 1 (even sense), a lane passes when its nine bits hold an even number of ones, and fails otherwise.
- R4: On a clock edge where `in_valid` is high, `parity_fail` is loaded with 1 if any lane fails and with 0 if all four pass. The new value is visible after that edge.
- R5: On a clock edge where `in_valid` is low, `parity_fail` keeps its value, whatever is on `in_word`.
- R6: Synchronous reset clears `parity_fail` and sets the mode bit to 0 (odd). Reset wins over a control write on the same edge.
- R7: A control write (`cfg_we` high) loads `cfg_wdata` into the mode bit at that edge. A word sampled on the same edge is checked with the old mode. Words sampled on later edges use the new mode.
- R8: While `cfg_we` is low, the mode bit keeps its value, whatever `cfg_wdata` carries.
- R9: The lanes are checked independently: a parity error confined to any single lane raises the flag on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The word on `in_word` is transferred this cycle |
| in_word | input | 36 | Four 9-bit lanes, each with its parity in the lane's top bit |
| cfg_we | input | 1 | Control-register write strobe |
| cfg_wdata | input | 1 | Value for control bit 0: 0 selects odd, 1 selects even |
| parity_fail | output | 1 | Registered: 1 when the last valid word had a failing lane |

## Verification
The hardest situation to reach from the ports is a control write and a valid word landing on the same edge. At that edge the word must still be judged by the old sense, and only the next word may see the new one. The bench builds this case directly. It drives a word that passes under odd parity and fails under even parity together with the write strobe, then holds the word for one more cycle, so the flag shows the old verdict and then the new one. The same bench also sweeps all 512 values of each lane under both senses, with the other three lanes held correct, so every single-lane error shows up alone.

// File: rtl/par_chk_pkg.sv
package par_chk_pkg;

    localparam int unsigned LANES_DEF     = 4;
    localparam int unsigned DATA_BITS_DEF = 8;

    typedef enum logic {
        PAR_ODD  = 1'b0,
        PAR_EVEN = 1'b1
    } par_mode_e;

    typedef struct packed {
        logic valid;
        logic any_fail;
    } chk_result_t;

    // Verdict for one lane, given whether its ones count is odd.
    function automatic logic lane_verdict_fail(input logic ones_odd, input par_mode_e m);
        return (m == PAR_ODD) ? ~ones_odd : ones_odd;
    endfunction

endpackage

// File: rtl/par_mode_reg.sv
module par_mode_reg
    import par_chk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      wr_bit,
    output par_mode_e mode
);

    always_ff @(posedge clk) begin
        if (rst)
            mode <= PAR_ODD;
        else if (wr_en)
            mode <= par_mode_e'(wr_bit);
    end

    // R6
    mode_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> mode == PAR_ODD);

    // R7
    mode_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en)) |-> mode == par_mode_e'($past(wr_bit)));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en)) |-> $stable(mode));

endmodule

// File: rtl/par_lane_chk.sv
module par_lane_chk
    import par_chk_pkg::*;
#(
    parameter int unsigned DATA_BITS = DATA_BITS_DEF,
    localparam int unsigned LANE_W   = DATA_BITS + 1
) (
    input  logic [LANE_W-1:0] lane,
    input  par_mode_e         mode,
    output logic              fail
);

    logic ones_odd;

    always_comb begin
        ones_odd = ^lane;
        fail     = lane_verdict_fail(ones_odd, mode);
    end

endmodule

// File: rtl/par_flag_reg.sv
module par_flag_reg
    import par_chk_pkg::*;
#(
    parameter int unsigned LANES = LANES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  chk_result_t      res,
    input  logic [LANES-1:0] lane_fail,
    output logic             flag
);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (res.valid)
            flag <= res.any_fail;
    end

    // R6
    flag_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !flag);

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (res.valid && lane_fail != '0) |=> flag);

    // R4
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (res.valid && lane_fail == '0) |=> !flag);

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(res.valid)) |-> $stable(flag));

endmodule

// File: rtl/byte_parity_checker.sv
module byte_parity_checker
    import par_chk_pkg::*;
#(
    parameter int unsigned LANES     = LANES_DEF,
    parameter int unsigned DATA_BITS = DATA_BITS_DEF,
    localparam int unsigned LANE_W   = DATA_BITS + 1,
    localparam int unsigned WORD_W   = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              cfg_we,
    input  logic              cfg_wdata,
    output logic              parity_fail
);

    par_mode_e        mode;
    logic [LANES-1:0] lane_fail;
    chk_result_t      res;

    par_mode_reg u_mode (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .wr_bit (cfg_wdata),
        .mode   (mode)
    );

    // R1: lane i sits at bits [i*LANE_W +: LANE_W]
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        par_lane_chk #(
            .DATA_BITS (DATA_BITS)
        ) u_lane (
            .lane (in_word[i*LANE_W +: LANE_W]),
            .mode (mode),
            .fail (lane_fail[i])
        );
    end

    always_comb begin
        res.valid    = in_valid;
        res.any_fail = |lane_fail;
    end

    par_flag_reg #(
        .LANES (LANES)
    ) u_flag (
        .clk       (clk),
        .rst       (rst),
        .res       (res),
        .lane_fail (lane_fail),
        .flag      (parity_fail)
    );

    // R9
    lane_alone_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && $onehot0(lane_fail) && lane_fail != '0) |=> parity_fail);

endmodule

// File: tb/test_byte_parity_checker.sv
`timescale 1ns/1ps
module test_byte_parity_checker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [35:0] in_word = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_wdata = 1'b0;
    logic        parity_fail;

    int checks = 0;
    int fails  = 0;
    logic cur_mode = 1'b0;  // 0 odd, 1 even

    always #2.5 clk = ~clk;

    byte_parity_checker i_byte_parity_checker (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_word     (in_word),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .parity_fail (parity_fail)
    );

    function automatic logic exp_fail(input logic [35:0] w, input logic m);
        logic f = 1'b0;
        for (int l = 0; l < 4; l++) begin
            int ones = 0;
            for (int b = 0; b < 9; b++) ones += int'(w[l*9 + b]);
            if (m == 1'b0 && (ones % 2) == 0) f = 1'b1;
            if (m == 1'b1 && (ones % 2) == 1) f = 1'b1;
        end
        return f;
    endfunction

    function automatic logic [8:0] good_lane(input logic [7:0] d, input logic m);
        int ones = 0;
        for (int b = 0; b < 8; b++) ones += int'(d[b]);
        // parity bit chosen so the nine-bit count is odd (m=0) or even (m=1)
        return {((ones % 2) == 0) ? ~m : m, d};
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: parity_fail=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic send(input logic [35:0] w, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
        check(parity_fail, exp_fail(w, cur_mode), req);
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = m;
        @(negedge clk);
        cfg_we    = 1'b0;
        cur_mode  = m;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [35:0] w;
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R6: flag cleared by reset
        check(parity_fail, 1'b0, "R6 reset state");

        // R1 R2 R3 R9: sweep each lane alone over all 512 values, both senses
        for (int m = 0; m < 2; m++) begin
            set_mode(m[0]);
            for (int l = 0; l < 4; l++) begin
                for (int v = 0; v < 512; v++) begin
                    for (int k = 0; k < 4; k++)
                        w[k*9 +: 9] = good_lane(8'(k * 37 + v), m[0]);
                    w[l*9 +: 9] = v[8:0];
                    send(w, m == 0 ? "R2 R1 R9 odd lane sweep" : "R3 R1 R9 even lane sweep");
                end
            end
        end

        // R4: mixed multi-lane words
        lfsr = 32'hACE1_1234;
        for (int n = 0; n < 300; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            w = {lfsr[3:0], lfsr, ~lfsr[31:28]} ^ 36'(n * 977);
            if (n == 150) set_mode(1'b0);
            send(w, "R4 mixed words");
        end

        // R5: flag holds while in_valid low
        send(36'h0, "R4 all-zero word fails odd");
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            in_word = {good_lane(8'h11, 1'b0), good_lane(8'h22, 1'b0),
                       good_lane(8'h33, 1'b0), good_lane(8'h44, 1'b0)};
            check(parity_fail, 1'b1, "R5 hold high");
        end
        send(in_word, "R4 passing word clears");
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            in_word = 36'(n);
            check(parity_fail, 1'b0, "R5 hold low");
        end

        // R7: write and word on the same edge
        w = {good_lane(8'h5A, 1'b0), good_lane(8'hC3, 1'b0),
             good_lane(8'h01, 1'b0), good_lane(8'hFF, 1'b0)};
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 1'b1; in_valid = 1'b1; in_word = w;
        @(negedge clk);
        cfg_we = 1'b0;
        check(parity_fail, 1'b0, "R7 same-edge word uses old mode");
        @(negedge clk);
        in_valid = 1'b0;
        check(parity_fail, 1'b1, "R7 next word uses new mode");
        cur_mode = 1'b1;

        // R8: mode holds while cfg_we low
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            cfg_wdata = n[0];
        end
        send(w, "R8 mode held even");
        send({good_lane(8'h12, 1'b1), good_lane(8'h34, 1'b1),
              good_lane(8'h56, 1'b1), good_lane(8'h78, 1'b1)}, "R8 even word passes");

        // R6: reset beats a write, restores odd, clears flag
        send(36'h0, "R4 zero word passes even");
        send(36'h1, "R4 single one fails even");
        @(negedge clk);
        rst = 1'b1; cfg_we = 1'b1; cfg_wdata = 1'b1;
        @(negedge clk);
        rst = 1'b0; cfg_we = 1'b0;
        cur_mode = 1'b0;
        check(parity_fail, 1'b0, "R6 reset clears flag");
        send(w, "R6 odd after reset, good word");
        send(36'h0, "R6 odd after reset, bad word");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule